// File: doc/BRIEF.md
# Adaptive Noise Level Tracker

The block keeps an 8-bit estimate of the line noise seen by a phoneline receiver. It is fed by a stream of single-cycle noise-event pulses. It raises the estimate one step when events arrive quickly, and it lowers the estimate one step when a long observation period ends quietly. The estimate always stays between a programmable floor and a programmable ceiling. A saturating counter records the total number of events seen, and software can clear it.

Software reaches the block through a simple register port. A write takes effect on the clock edge where `cfg_wr_i` is high. Reads are combinational from `cfg_addr_i`. The same port holds a link-disable bit and a four-wire enable bit. The four-wire bit is latched from a strap pin during reset, and it can only be changed afterwards if that strap was high. The observation period is a parameter in clock ticks. At a 100 MHz clock, the default gives 870 ms.

Top module: `noise_tracker_top`

## Requirements
- R1: After reset, the registers read as follows. Address 0 (floor) reads 0x07, address 1 (ceiling) reads 0x80 and address 2 (attack) reads 0xF4. Address 3 (event count) reads 0x00 and address 6 (current level) reads 0x07.
- R2: On the clock after any floor or ceiling write, the level lies within [floor, ceiling]. If the floor exceeds the ceiling, the level equals the floor.
- R3: The attack high nibble is the immediate threshold; a value of zero disables this rule. When the immediate tally, counting the event in the current cycle, reaches this threshold, the level rises by one on that clock edge. The level never rises past the ceiling, and the immediate tally restarts at zero.
- R4: At each period end, the period tally (counting the event in that cycle) is compared with the attack low nibble. If the tally is equal or greater, the level rises by one. Otherwise the level falls by one, but never below the floor. Both tallies restart at zero. A cycle that meets both the immediate rule and the period rule gives a single step.
- R5: The first period ends on the PERIOD_TICKS-th rising edge after reset is released. After that, a period ends every PERIOD_TICKS edges.
- R6: The event count (address 3) rises by one on each edge where `noise_ev_i` is high. It holds at 0xFF and never wraps.
- R7: A write to address 4 with bit 6 set clears the event count to 0. The clear wins over an event in the same cycle. A write to address 4 with bit 6 clear leaves the count unchanged.
- R8: Address 5 reads with bits 7:2 as 0, bit 1 as the link-disable bit and bit 0 as the four-wire enable bit. Bit 1 can be written and read back, and it drives `link_dis_o`.
- R9: The four-wire bit resets to the value of `strap_4w_i` during reset. It can be written only if that strap value was 1. If the strap value was 0, writes to this bit are ignored and it stays 0.
- R10: Address 4 and address 7 always read 0. Writes to addresses 3, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_4w_i | input | 1 | Four-wire strap, sampled while in reset |
| noise_ev_i | input | 1 | One-cycle pulse per detected noise event |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | W | Register write data |
| cfg_rdata_o | output | W | Register read data, combinational from the address |
| level_o | output | W | Current noise level estimate |
| four_wire_o | output | 1 | Four-wire enable bit |
| link_dis_o | output | 1 | Link-disable bit |

## Verification
The bench checks the level on every cycle against a model built from the requirements. A design that misplaces the period boundary by one edge, or takes two steps when an immediate raise and a period end coincide, would therefore diverge within one period. The bench writes a ceiling below the floor. A design that lets the ceiling win, or clamps late, would show a level other than the floor. It drives long bursts to push the event count past 0xFF, where a wrapping counter would read a small value. It clears the count in the same cycle as an event, where giving the event priority would leave 1. It resets once with the strap low, where a design that ignores the lock would let the four-wire bit be written.

// File: rtl/nt_pkg.sv
package nt_pkg;
    typedef enum logic [2:0] {
        A_FLOOR  = 3'd0,
        A_CEIL   = 3'd1,
        A_ATTACK = 3'd2,
        A_EVENTS = 3'd3,
        A_CTRL   = 3'd4,
        A_LINK   = 3'd5,
        A_LEVEL  = 3'd6,
        A_SPARE  = 3'd7
    } reg_addr_e;

    localparam int unsigned CLR_BIT = 6;
endpackage

// File: rtl/nt_regs.sv
module nt_regs
    import nt_pkg::*;
#(
    parameter int W = 8,
    parameter logic [W-1:0] FLOOR_RST  = 8'h07,
    parameter logic [W-1:0] CEIL_RST   = 8'h80,
    parameter logic [W-1:0] ATTACK_RST = 8'hF4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap_i,
    input  logic         wr_i,
    input  logic [2:0]   addr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] floor_o,
    output logic [W-1:0] ceil_o,
    output logic [W-1:0] attack_o,
    output logic         link_dis_o,
    output logic         fw_o,
    output logic         clr_o
);
    typedef struct packed {
        logic [W-1:0] floor;
        logic [W-1:0] ceil;
        logic [W-1:0] attack;
        logic         link_dis;
        logic         fw;
        logic         strap;
    } regs_t;

    regs_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            case (addr_i)
                A_FLOOR:  s_d.floor  = wdata_i;
                A_CEIL:   s_d.ceil   = wdata_i;
                A_ATTACK: s_d.attack = wdata_i;
                A_LINK: begin
                    s_d.link_dis = wdata_i[1];
                    if (s_q.strap) s_d.fw = wdata_i[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.floor    <= FLOOR_RST;
            s_q.ceil     <= CEIL_RST;
            s_q.attack   <= ATTACK_RST;
            s_q.link_dis <= 1'b0;
            s_q.fw       <= strap_i;
            s_q.strap    <= strap_i;
        end else begin
            s_q <= s_d;
        end
    end

    assign floor_o    = s_q.floor;
    assign ceil_o     = s_q.ceil;
    assign attack_o   = s_q.attack;
    assign link_dis_o = s_q.link_dis;
    assign fw_o       = s_q.fw;
    assign clr_o      = wr_i && (addr_i == A_CTRL) && wdata_i[CLR_BIT];

    assert_strap_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.strap |-> !fw_o);

    assert_link_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_LINK) |=> (link_dis_o == $past(wdata_i[1])));
endmodule

// File: rtl/nt_timer.sv
module nt_timer #(
    parameter int unsigned TICKS = 87_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic pend_o
);
    localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CW-1:0] cnt_q, cnt_d;

    assign pend_o = (cnt_q == CW'(TICKS - 1));

    always_comb begin
        cnt_d = pend_o ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_timer_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_q} < (CW+1)'(TICKS)));
endmodule

// File: rtl/nt_level.sv
module nt_level #(
    parameter int W = 8,
    parameter logic [W-1:0] LVL_RST = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_i,
    input  logic         pend_i,
    input  logic [W-1:0] floor_i,
    input  logic [W-1:0] ceil_i,
    input  logic [W-1:0] attack_i,
    output logic [W-1:0] level_o
);
    localparam int NW = W / 2;
    localparam int TW = NW + 1;

    typedef struct packed {
        logic [W-1:0]  level;
        logic [NW-1:0] imm;
        logic [NW-1:0] per;
    } lvl_t;

    lvl_t q, d;

    logic [NW-1:0] hi, lo;
    logic [TW-1:0] imm_sum, per_sum;
    logic          raise_imm, step_up, step_dn;
    logic [W-1:0]  lvl;

    always_comb begin
        hi        = attack_i[W-1:NW];
        lo        = attack_i[NW-1:0];
        imm_sum   = {1'b0, q.imm} + TW'(ev_i);
        per_sum   = {1'b0, q.per} + TW'(ev_i);
        raise_imm = ev_i && (hi != '0) && (imm_sum >= {1'b0, hi});
        step_up   = raise_imm || (pend_i && (per_sum >= {1'b0, lo}));
        step_dn   = pend_i && !step_up;

        lvl = q.level;
        if (step_up && lvl < ceil_i)       lvl = lvl + W'(1);
        else if (step_dn && lvl > floor_i) lvl = lvl - W'(1);
        if (lvl > ceil_i)  lvl = ceil_i;
        if (lvl < floor_i) lvl = floor_i;

        d.level = lvl;
        if (pend_i || raise_imm) d.imm = '0;
        else                     d.imm = imm_sum[NW] ? '1 : imm_sum[NW-1:0];
        if (pend_i)              d.per = '0;
        else                     d.per = per_sum[NW] ? '1 : per_sum[NW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.level <= LVL_RST;
            q.imm   <= '0;
            q.per   <= '0;
        end else begin
            q <= d;
        end
    end

    assign level_o = q.level;

    assert_level_ceil_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(floor_i) && $stable(ceil_i) && floor_i <= ceil_i) |-> (level_o <= ceil_i));

    assert_level_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(floor_i) && $stable(ceil_i)) |-> (level_o >= floor_i));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(floor_i) && $stable(ceil_i) &&
         $past(level_o) >= floor_i && $past(level_o) <= ceil_i)
        |-> (level_o == $past(level_o) ||
             level_o == $past(level_o) + W'(1) ||
             level_o == $past(level_o) - W'(1)));
endmodule

// File: rtl/nt_evcnt.sv
module nt_evcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                     cnt_d = '0;
        else if (ev_i && cnt_q != '1)  cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    assert_count_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1 && !clr_i) |=> (cnt_q == '1));

    assert_count_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/noise_tracker_top.sv
module noise_tracker_top
    import nt_pkg::*;
#(
    parameter int          W            = 8,
    parameter int unsigned PERIOD_TICKS = 87_000_000,
    parameter logic [W-1:0] FLOOR_RST   = 8'h07,
    parameter logic [W-1:0] CEIL_RST    = 8'h80,
    parameter logic [W-1:0] ATTACK_RST  = 8'hF4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap_4w_i,
    input  logic         noise_ev_i,
    input  logic         cfg_wr_i,
    input  logic [2:0]   cfg_addr_i,
    input  logic [W-1:0] cfg_wdata_i,
    output logic [W-1:0] cfg_rdata_o,
    output logic [W-1:0] level_o,
    output logic         four_wire_o,
    output logic         link_dis_o
);
    logic [W-1:0] floor_w, ceil_w, attack_w, count_w;
    logic         clr_w, pend_w;

    nt_regs #(
        .W(W), .FLOOR_RST(FLOOR_RST), .CEIL_RST(CEIL_RST), .ATTACK_RST(ATTACK_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_4w_i),
        .wr_i(cfg_wr_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
        .floor_o(floor_w), .ceil_o(ceil_w), .attack_o(attack_w),
        .link_dis_o(link_dis_o), .fw_o(four_wire_o), .clr_o(clr_w)
    );

    nt_timer #(.TICKS(PERIOD_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .pend_o(pend_w)
    );

    nt_level #(.W(W), .LVL_RST(FLOOR_RST)) u_level (
        .clk(clk), .rst_n(rst_n), .ev_i(noise_ev_i), .pend_i(pend_w),
        .floor_i(floor_w), .ceil_i(ceil_w), .attack_i(attack_w), .level_o(level_o)
    );

    nt_evcnt #(.W(W)) u_evcnt (
        .clk(clk), .rst_n(rst_n), .ev_i(noise_ev_i), .clr_i(clr_w), .cnt_o(count_w)
    );

    always_comb begin
        case (cfg_addr_i)
            A_FLOOR:  cfg_rdata_o = floor_w;
            A_CEIL:   cfg_rdata_o = ceil_w;
            A_ATTACK: cfg_rdata_o = attack_w;
            A_EVENTS: cfg_rdata_o = count_w;
            A_LINK:   cfg_rdata_o = {{(W-2){1'b0}}, link_dis_o, four_wire_o};
            A_LEVEL:  cfg_rdata_o = level_o;
            default:  cfg_rdata_o = '0;
        endcase
    end
endmodule

// File: tb/noise_tracker_top_test.sv
`timescale 1ns/1ps
module noise_tracker_top_test;
    localparam int P = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap = 1'b1;
    logic       ev = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, level;
    logic       fw, lnk;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] m_floor, m_ceil, m_att, m_lvl;
    logic       m_lnk, m_fw, m_strap;
    int         m_imm, m_per, m_cnt, m_t;
    logic [7:0] exp_q[$];

    noise_tracker_top #(.W(8), .PERIOD_TICKS(P)) uut (
        .clk(clk), .rst_n(rst_n), .strap_4w_i(strap), .noise_ev_i(ev),
        .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .cfg_rdata_o(rdata), .level_o(level), .four_wire_o(fw), .link_dis_o(lnk)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, expv, $time);
        end
    endtask

    // Reference model driven by the requirements; pushes the expected level each edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_floor = 8'h07; m_ceil = 8'h80; m_att = 8'hF4; m_lvl = 8'h07;
            m_lnk = 1'b0; m_strap = strap; m_fw = strap;
            m_imm = 0; m_per = 0; m_cnt = 0; m_t = 0;
            exp_q.delete();
        end else begin
            int hi, lo, is, ps, l;
            bit pend, ri, up, dn;
            hi = int'(m_att[7:4]); lo = int'(m_att[3:0]);
            pend = (m_t == P - 1);
            is = m_imm + int'(ev); ps = m_per + int'(ev);
            ri = ev && hi != 0 && is >= hi;
            up = ri || (pend && ps >= lo);
            dn = pend && !up;
            l = int'(m_lvl);
            if (up && l < int'(m_ceil)) l++;
            else if (dn && l > int'(m_floor)) l--;
            if (l > int'(m_ceil))  l = int'(m_ceil);
            if (l < int'(m_floor)) l = int'(m_floor);
            m_lvl = l[7:0];
            m_imm = (pend || ri) ? 0 : ((is > 15) ? 15 : is);
            m_per = pend ? 0 : ((ps > 15) ? 15 : ps);
            m_t = pend ? 0 : m_t + 1;
            if (wr && addr == 3'd4 && wdata[6]) m_cnt = 0;
            else if (ev && m_cnt != 255) m_cnt++;
            if (wr) begin
                case (addr)
                    3'd0: m_floor = wdata;
                    3'd1: m_ceil = wdata;
                    3'd2: m_att = wdata;
                    3'd5: begin m_lnk = wdata[1]; if (m_strap) m_fw = wdata[0]; end
                    default: ;
                endcase
            end
            exp_q.push_back(m_lvl);
        end
    end

    // Monitor: compares level output with the scoreboard every cycle (R2/R3/R4/R5).
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk("R2/R3/R4/R5 level", level, e);
        end
    end

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_floor;
            3'd1: return m_ceil;
            3'd2: return m_att;
            3'd3: return m_cnt[7:0];
            3'd5: return {6'b0, m_lnk, m_fw};
            3'd6: return m_lvl;
            default: return 8'h00;
        endcase
    endfunction

    task automatic rd(input logic [2:0] a, input string tag);
        @(negedge clk); addr = a; #1;
        chk(tag, rdata, exp_read(a));
    endtask

    task automatic rd_lit(input logic [2:0] a, input logic [7:0] v, input string tag);
        @(negedge clk); addr = a; #1;
        chk(tag, rdata, v);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic pulses(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ev = 1'b1;
            @(negedge clk); ev = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic burst(input int n);
        @(negedge clk); ev = 1'b1;
        repeat (n) @(negedge clk);
        ev = 1'b0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements): got hung run expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd_lit(3'd0, 8'h07, "R1 floor");
        rd_lit(3'd1, 8'h80, "R1 ceiling");
        rd_lit(3'd2, 8'hF4, "R1 attack");
        rd_lit(3'd3, 8'h00, "R1 events");
        rd_lit(3'd6, 8'h07, "R1 level");
        rd_lit(3'd5, 8'h01, "R8 strap high");
        rd_lit(3'd4, 8'h00, "R10 control");
        rd_lit(3'd7, 8'h00, "R10 spare");
        // R3 immediate raise with high nibble 3, R4 period raise with low nibble 2
        wreg(3'd2, 8'h32);
        pulses(3, 1);
        rd(3'd6, "R3 level after immediate");
        pulses(2, 6);
        repeat (P) @(negedge clk);
        rd(3'd6, "R4 level after period");
        // R4 decay toward floor over quiet periods
        repeat (6 * P) @(negedge clk);
        rd_lit(3'd6, 8'h07, "R4 decay holds at floor");
        // R10 writes to read-only addresses change nothing
        wreg(3'd3, 8'h55);
        wreg(3'd6, 8'h55);
        rd(3'd3, "R10 events after write");
        rd(3'd6, "R10 level after write");
        // R2 conflicting bounds: floor wins
        pulses(12, 0);
        wreg(3'd1, 8'h05);
        rd_lit(3'd6, 8'h07, "R2 floor above ceiling");
        wreg(3'd1, 8'h0A);
        wreg(3'd0, 8'h09);
        rd_lit(3'd6, 8'h09, "R2 floor raised");
        // R3 every event raises, capped at ceiling; R6 saturation
        wreg(3'd2, 8'h10);
        burst(300);
        rd_lit(3'd6, 8'h0A, "R3 capped at ceiling");
        rd_lit(3'd3, 8'hFF, "R6 saturated");
        // R7 clear wins over a same-cycle event
        @(negedge clk); wr = 1'b1; addr = 3'd4; wdata = 8'h40; ev = 1'b1;
        @(negedge clk); wr = 1'b0; ev = 1'b0;
        rd_lit(3'd3, 8'h00, "R7 clear beats event");
        pulses(2, 0);
        wreg(3'd4, 8'hBF);
        rd_lit(3'd3, 8'h02, "R7 no clear without bit 6");
        // R4 low nibble zero: every period raises
        wreg(3'd1, 8'h80);
        wreg(3'd2, 8'h00);
        repeat (3 * P) @(negedge clk);
        rd(3'd6, "R4 zero threshold raise");
        // R8 and R9 with strap high
        wreg(3'd5, 8'hFE);
        rd_lit(3'd5, 8'h02, "R8 link set, four-wire cleared");
        wreg(3'd5, 8'h01);
        rd_lit(3'd5, 8'h01, "R9 four-wire writable");
        chk("R8 link output", {7'b0, lnk}, 8'h00);
        // R9 strap low locks the bit
        @(negedge clk); #2; rst_n = 1'b0; strap = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_lit(3'd5, 8'h00, "R9 strap low reset");
        wreg(3'd5, 8'h03);
        rd_lit(3'd5, 8'h02, "R9 four-wire write ignored");
        chk("R9 four-wire output", {7'b0, fw}, 8'h00);
        pulses(4, 2);
        repeat (2 * P) @(negedge clk);
        rd(3'd6, "R5 level after reset periods");
        finish_run();
    end
endmodule